// File: doc/BRIEF.md
# PC Card Host Access Decoder

This block is the host-facing front end of an 8-bit PC Card function. It watches the card-side strobes (region select, card enable, output enable, write enable, I/O read, I/O write) and address bit 0. From them it works out what kind of cycle the host is running: standby, a common memory read or write, an attribute memory read or write, or an I/O read or write. Bit 0 of the address picks the even or the odd byte. All host inputs pass through a short resynchronising register chain before they are decoded.

Every access that the block accepts, except one aimed at its own configuration option register, becomes a request on a backend port. The block holds the host cycle open with an active-low wait line until the backend accepts the request. Read data is captured at that moment and driven onto the host data bus, and only during read cycles. The configuration option register sits at a fixed attribute-memory address. The active-high reset clears it. While its index field is zero the card stays memory-only and ignores I/O strobes. The block also drives an active-low wakeup line and a reset output for the function units behind it.

Backend back-pressure follows valid/ready rules. Once `be_valid_o` rises, it and every request field stay unchanged until the cycle in which `be_ready_i` is high. That cycle completes the transfer, and `be_rdata_i` must be valid in it. The backend may keep `be_ready_i` low for as long as it needs.

Top module: `pcc_host_decoder`

## Requirements
- R1: While the sampled card enable is high (standby), the block raises no backend request, does not drive the data bus (`d_oe_o` low) and keeps `wait_n_o` high, whatever the other strobes do.
- R2: With region select high, I/O read and I/O write both high, and output enable low with write enable high, the block issues a common memory read. The reverse output/write enable pair issues a common memory write. Common memory is space code 0 on `be_space_o`.
- R3: With region select low, I/O read and I/O write both high, the same output/write enable pairs issue attribute memory reads and writes. Attribute memory is space code 1.
- R4: With region select low, output and write enable both high, and I/O enabled: I/O read low alone issues an I/O read, and I/O write low alone issues an I/O write. I/O is space code 2.
- R5: Any strobe pattern not named in R2 to R4 (for example, output and write enable both low) is no access: no request, no bus drive, and `wait_n_o` stays high.
- R6: `be_addr_o` carries the full byte address, with A0 in bit 0 (0 = even byte, 1 = odd byte). `be_write_o` is 1 for writes, and `be_wdata_o` carries the host write byte.
- R7: `wait_n_o` goes low SYNC_STAGES clocks after a valid strobe pattern is applied. It stays low while the request is pending and returns high in the clock after the accepting edge.
- R8: On a read, the data accepted from the backend is on `d_o` with `d_oe_o` high from the moment `wait_n_o` returns high until the strobes are withdrawn. `d_oe_o` is never high on a write.
- R9: While `be_valid_o` is high and `be_ready_i` is low, the request (valid, address, space, write flag and write data) holds steady.
- R10: An attribute access at byte address CFG_ADDR reaches the configuration option register and raises no backend request. A write stores the byte, and a read returns the stored byte.
- R11: Reset clears the configuration option register to 0. While its low six bits (the index) are zero, I/O strobe patterns are ignored as in R5. A nonzero index enables I/O.
- R12: `stschg_n_o` goes low one clock after `wake_i` is high and follows it. `func_rst_o` is high during reset and falls at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Active-high reset |
| reg_n_i | input | 1 | Region select, low for attribute memory or I/O |
| ce1_n_i | input | 1 | Card enable, high for standby |
| oe_n_i | input | 1 | Memory output enable, active low |
| we_n_i | input | 1 | Memory write enable, active low |
| iord_n_i | input | 1 | I/O read strobe, active low |
| iowr_n_i | input | 1 | I/O write strobe, active low |
| a0_i | input | 1 | Address bit 0, byte select |
| addr_hi_i | input | ADDR_W-1 | Address bits above bit 0 |
| d_i | input | 8 | Host write data |
| d_o | output | 8 | Host read data |
| d_oe_o | output | 1 | Data bus drive enable |
| wait_n_o | output | 1 | Cycle extension, active low |
| stschg_n_o | output | 1 | Wakeup indication, active low |
| wake_i | input | 1 | Internal wakeup request |
| func_rst_o | output | 1 | Reset to the function units |
| be_valid_o | output | 1 | Backend request valid |
| be_ready_i | input | 1 | Backend accepts (acknowledge) |
| be_write_o | output | 1 | Request is a write |
| be_space_o | output | 2 | 0 common, 1 attribute, 2 I/O |
| be_addr_o | output | ADDR_W | Byte address, A0 in bit 0 |
| be_wdata_o | output | 8 | Write data |
| be_rdata_i | input | 8 | Read data, valid with ready |

## Verification
The bench builds the block with ADDR_W of 10, CFG_ADDR of 0x3F8 and SYNC_STAGES of 3. The short address lets random addresses sweep the whole space, including the neighbours of the configuration address. The three-stage sampler makes the wait timing depend on the parameter rather than on a fixed one- or two-clock habit. Backend latency varies from zero to several clocks, so both the same-cycle acceptance path and the held request are exercised.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ACC_NONE  = 3'd0,
    ACC_CM_RD = 3'd1,
    ACC_CM_WR = 3'd2,
    ACC_AT_RD = 3'd3,
    ACC_AT_WR = 3'd4,
    ACC_IO_RD = 3'd5,
    ACC_IO_WR = 3'd6
  } acc_kind_e;

  localparam logic [1:0] SP_COMMON = 2'd0;
  localparam logic [1:0] SP_ATTR   = 2'd1;
  localparam logic [1:0] SP_IO     = 2'd2;

  typedef struct packed {
    logic reg_n;
    logic ce1_n;
    logic oe_n;
    logic we_n;
    logic iord_n;
    logic iowr_n;
  } strobes_t;

  function automatic logic kind_is_read(acc_kind_e k);
    return (k == ACC_CM_RD) || (k == ACC_AT_RD) || (k == ACC_IO_RD);
  endfunction

  function automatic logic kind_is_write(acc_kind_e k);
    return (k == ACC_CM_WR) || (k == ACC_AT_WR) || (k == ACC_IO_WR);
  endfunction

  function automatic logic [1:0] kind_space(acc_kind_e k);
    case (k)
      ACC_AT_RD, ACC_AT_WR: return SP_ATTR;
      ACC_IO_RD, ACC_IO_WR: return SP_IO;
      default:              return SP_COMMON;
    endcase
  endfunction
endpackage

// File: rtl/pcc_sampler.sv
module pcc_sampler #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) stg[g] <= RST_VAL;
      else if (g == 0) stg[g] <= d_i;
      else stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pcc_decode.sv
module pcc_decode
  import pcc_pkg::*;
(
  input  strobes_t  stb_i,
  input  logic      io_en_i,
  output acc_kind_e kind_o
);
  logic io_idle;
  logic mem_idle;
  logic mem_rd;
  logic mem_wr;
  logic io_rd;
  logic io_wr;

  always_comb begin
    io_idle  = stb_i.iord_n && stb_i.iowr_n;
    mem_idle = stb_i.oe_n && stb_i.we_n;
    mem_rd   = !stb_i.oe_n && stb_i.we_n;
    mem_wr   = stb_i.oe_n && !stb_i.we_n;
    io_rd    = !stb_i.iord_n && stb_i.iowr_n;
    io_wr    = stb_i.iord_n && !stb_i.iowr_n;
    kind_o   = ACC_NONE;
    if (!stb_i.ce1_n) begin
      if (io_idle) begin
        if (mem_rd)      kind_o = stb_i.reg_n ? ACC_CM_RD : ACC_AT_RD;
        else if (mem_wr) kind_o = stb_i.reg_n ? ACC_CM_WR : ACC_AT_WR;
      end else if (!stb_i.reg_n && mem_idle && io_en_i) begin
        if (io_rd)      kind_o = ACC_IO_RD;
        else if (io_wr) kind_o = ACC_IO_WR;
      end
    end
  end
endmodule

// File: rtl/pcc_cfg_reg.sv
module pcc_cfg_reg
  import pcc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cor_o,
  output logic              io_en_o
);
  logic [DATA_W-1:0] cor_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) cor_q <= '0;
    else if (wr_i) cor_q <= wdata_i;
  end

  assign cor_o   = cor_q;
  assign io_en_o = |cor_q[IDX_W-1:0];

  p_cfg_capture_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_i |=> (cor_q == $past(wdata_i)));

  p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_i |=> $stable(cor_q));
endmodule

// File: rtl/pcc_access_fsm.sv
module pcc_access_fsm
  import pcc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  acc_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cfg_hit_i,
  input  logic [DATA_W-1:0] cor_i,
  output logic              cfg_wr_o,
  output logic              wait_n_o,
  output logic [DATA_W-1:0] d_o,
  output logic              d_oe_o,
  output logic              be_valid_o,
  input  logic              be_ready_i,
  output logic              be_write_o,
  output logic [1:0]        be_space_o,
  output logic [ADDR_W-1:0] be_addr_o,
  output logic [DATA_W-1:0] be_wdata_o,
  input  logic [DATA_W-1:0] be_rdata_i
);
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} state_e;

  state_e            state_q;
  acc_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_q;
  logic              access_now;
  logic              cfg_now;

  assign access_now = (kind_i != ACC_NONE);
  assign cfg_now    = cfg_hit_i && ((kind_i == ACC_AT_RD) || (kind_i == ACC_AT_WR));

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      kind_q  <= ACC_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (access_now) begin
            kind_q  <= kind_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            if (cfg_now) begin
              if (kind_is_read(kind_i)) rd_q <= cor_i;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_BUSY;
            end
          end
        end
        ST_BUSY: begin
          if (be_ready_i) begin
            if (kind_is_read(kind_q)) rd_q <= be_rdata_i;
            state_q <= ST_DONE;
          end
        end
        default: begin
          if (kind_i != kind_q) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign cfg_wr_o   = (state_q == ST_IDLE) && cfg_now && (kind_i == ACC_AT_WR);
  assign wait_n_o   = !(((state_q == ST_IDLE) && access_now) || (state_q == ST_BUSY));
  assign d_oe_o     = (state_q == ST_DONE) && kind_is_read(kind_q) && (kind_i == kind_q);
  assign d_o        = rd_q;
  assign be_valid_o = (state_q == ST_BUSY);
  assign be_write_o = kind_is_write(kind_q);
  assign be_space_o = kind_space(kind_q);
  assign be_addr_o  = addr_q;
  assign be_wdata_o = wdata_q;

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (be_valid_o && !be_ready_i) |=> (be_valid_o && $stable(be_addr_o) &&
      $stable(be_wdata_o) && $stable(be_write_o) && $stable(be_space_o)));

  p_wait_release_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (be_valid_o && be_ready_i) |=> wait_n_o);

  p_drive_reads_only_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    d_oe_o |-> kind_is_read(kind_i));

  p_read_data_steady_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (d_oe_o && $past(d_oe_o)) |-> $stable(d_o));
endmodule

// File: rtl/pcc_host_decoder.sv
module pcc_host_decoder
  import pcc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 12'h200
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              reg_n_i,
  input  logic              ce1_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic              iord_n_i,
  input  logic              iowr_n_i,
  input  logic              a0_i,
  input  logic [ADDR_W-2:0] addr_hi_i,
  input  logic [7:0]        d_i,
  output logic [7:0]        d_o,
  output logic              d_oe_o,
  output logic              wait_n_o,
  output logic              stschg_n_o,
  input  logic              wake_i,
  output logic              func_rst_o,
  output logic              be_valid_o,
  input  logic              be_ready_i,
  output logic              be_write_o,
  output logic [1:0]        be_space_o,
  output logic [ADDR_W-1:0] be_addr_o,
  output logic [7:0]        be_wdata_o,
  input  logic [7:0]        be_rdata_i
);
  localparam int STB_W  = $bits(strobes_t);
  localparam int PATH_W = ADDR_W + DATA_W;

  strobes_t          stb_raw;
  strobes_t          stb_s;
  logic [STB_W-1:0]  stb_vec;
  logic [PATH_W-1:0] path_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] wdata_s;
  acc_kind_e         kind;
  logic              io_en;
  logic              cfg_wr;
  logic [DATA_W-1:0] cor;
  logic              cfg_hit;
  logic              func_rst_q;
  logic              wake_q;

  assign stb_raw = '{reg_n: reg_n_i, ce1_n: ce1_n_i, oe_n: oe_n_i,
                     we_n: we_n_i, iord_n: iord_n_i, iowr_n: iowr_n_i};

  pcc_sampler #(.W(STB_W), .STAGES(SYNC_STAGES), .RST_VAL({STB_W{1'b1}})) u_stb_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(stb_raw), .q_o(stb_vec)
  );

  pcc_sampler #(.W(PATH_W), .STAGES(SYNC_STAGES), .RST_VAL({PATH_W{1'b0}})) u_path_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i({addr_hi_i, a0_i, d_i}), .q_o(path_s)
  );

  assign stb_s   = strobes_t'(stb_vec);
  assign addr_s  = path_s[PATH_W-1:DATA_W];
  assign wdata_s = path_s[DATA_W-1:0];
  assign cfg_hit = (addr_s == CFG_ADDR);

  pcc_decode u_decode (
    .stb_i(stb_s), .io_en_i(io_en), .kind_o(kind)
  );

  pcc_cfg_reg #(.IDX_W(6)) u_cfg (
    .clk_i(clk_i), .rst_i(rst_i), .wr_i(cfg_wr), .wdata_i(wdata_s),
    .cor_o(cor), .io_en_o(io_en)
  );

  pcc_access_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i(clk_i), .rst_i(rst_i), .kind_i(kind), .addr_i(addr_s),
    .wdata_i(wdata_s), .cfg_hit_i(cfg_hit), .cor_i(cor), .cfg_wr_o(cfg_wr),
    .wait_n_o(wait_n_o), .d_o(d_o), .d_oe_o(d_oe_o),
    .be_valid_o(be_valid_o), .be_ready_i(be_ready_i), .be_write_o(be_write_o),
    .be_space_o(be_space_o), .be_addr_o(be_addr_o), .be_wdata_o(be_wdata_o),
    .be_rdata_i(be_rdata_i)
  );

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      func_rst_q <= 1'b1;
      wake_q     <= 1'b0;
    end else begin
      func_rst_q <= 1'b0;
      wake_q     <= wake_i;
    end
  end

  assign func_rst_o = func_rst_q;
  assign stschg_n_o = !wake_q;

  p_standby_quiet_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    stb_s.ce1_n |-> !d_oe_o);

  p_io_gated_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    !io_en |-> !(be_valid_o && (be_space_o == SP_IO)));

  p_wake_follow_r12: assert property (@(posedge clk_i) disable iff (rst_i)
    wake_i |=> !stschg_n_o);
endmodule

// File: tb/pcc_host_decoder_tb.sv
module pcc_host_decoder_tb;
  localparam int AW = 10;
  localparam int S  = 3;
  localparam logic [AW-1:0] CFG = 10'h3F8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_n = 1'b1, ce1_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, iord_n = 1'b1, iowr_n = 1'b1;
  logic a0 = 1'b0;
  logic [AW-2:0] addr_hi = '0;
  logic [7:0] d_in = '0;
  logic [7:0] d_out;
  logic d_oe, wait_n, stschg_n, func_rst;
  logic wake = 1'b0;
  logic be_valid, be_write;
  logic be_ready = 1'b0;
  logic [1:0] be_space;
  logic [AW-1:0] be_addr;
  logic [7:0] be_wdata;
  logic [7:0] be_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] cor_model = '0;

  always #2 clk = ~clk;

  pcc_host_decoder #(.ADDR_W(AW), .SYNC_STAGES(S), .CFG_ADDR(CFG)) u_dut (
    .clk_i(clk), .rst_i(rst), .reg_n_i(reg_n), .ce1_n_i(ce1_n), .oe_n_i(oe_n),
    .we_n_i(we_n), .iord_n_i(iord_n), .iowr_n_i(iowr_n), .a0_i(a0),
    .addr_hi_i(addr_hi), .d_i(d_in), .d_o(d_out), .d_oe_o(d_oe),
    .wait_n_o(wait_n), .stschg_n_o(stschg_n), .wake_i(wake),
    .func_rst_o(func_rst), .be_valid_o(be_valid), .be_ready_i(be_ready),
    .be_write_o(be_write), .be_space_o(be_space), .be_addr_o(be_addr),
    .be_wdata_o(be_wdata), .be_rdata_i(be_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // stb = {reg, ce1, oe, we, iord, iowr}
  function automatic int exp_kind(logic [5:0] s, bit ioen);
    if (s[4]) return 0;
    if (s[1] && s[0]) begin
      if (!s[3] && s[2]) return s[5] ? 1 : 3;
      if (s[3] && !s[2]) return s[5] ? 2 : 4;
      return 0;
    end
    if (!s[5] && s[3] && s[2]) begin
      if (!s[1] && s[0]) return ioen ? 5 : 0;
      if (s[1] && !s[0]) return ioen ? 6 : 0;
    end
    return 0;
  endfunction

  function automatic logic [7:0] mem_val(logic [AW-1:0] a);
    return 8'(a ^ (a >> 3)) ^ 8'h3C;
  endfunction

  function automatic string kind_tag(int k);
    if (k == 1 || k == 2) return "R2";
    if (k == 3 || k == 4) return "R3";
    return "R4";
  endfunction

  task automatic set_stb(logic [5:0] s);
    {reg_n, ce1_n, oe_n, we_n, iord_n, iowr_n} = s;
  endtask

  task automatic access(input logic [5:0] stb, input logic [AW-1:0] a, input logic [7:0] wd,
                        input int lat, input string tag0);
    int k;
    bit cfg, rd;
    string t;
    k   = exp_kind(stb, cor_model[5:0] != 0);
    cfg = (k == 3 || k == 4) && (a == CFG);
    rd  = (k == 1 || k == 3 || k == 5);
    t   = (k == 0) ? tag0 : (cfg ? "R10" : kind_tag(k));
    @(negedge clk);
    set_stb(stb);
    {addr_hi, a0} = a;
    d_in = wd;
    repeat (S) @(posedge clk);
    @(negedge clk);
    if (k == 0) begin
      for (int i = 0; i < 3; i++) begin
        chk(wait_n == 1'b1, t, "no-access wait_n", wait_n, 1);
        chk(be_valid == 1'b0, t, "no-access be_valid", be_valid, 0);
        chk(d_oe == 1'b0, t, "no-access d_oe", d_oe, 0);
        @(negedge clk);
      end
    end else begin
      chk(wait_n == 1'b0, "R7", "wait asserted", wait_n, 0);
      @(negedge clk);
      if (cfg) begin
        chk(be_valid == 1'b0, "R10", "cfg no request", be_valid, 0);
        chk(wait_n == 1'b1, "R10", "cfg wait released", wait_n, 1);
        if (rd) begin
          chk(d_oe == 1'b1, "R10", "cfg read drive", d_oe, 1);
          chk(d_out == cor_model, "R10", "cfg read data", d_out, cor_model);
        end else begin
          cor_model = wd;
        end
      end else begin
        chk(be_valid == 1'b1, t, "request valid", be_valid, 1);
        chk(be_space == ((k <= 2) ? 2'd0 : (k <= 4) ? 2'd1 : 2'd2), t, "space", be_space,
            (k <= 2) ? 0 : (k <= 4) ? 1 : 2);
        chk(be_write == !rd, t, "write flag", be_write, !rd);
        chk(be_addr == a, "R6", "byte address", be_addr, a);
        if (!rd) chk(be_wdata == wd, "R6", "write data", be_wdata, wd);
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          chk(be_valid == 1'b1 && be_addr == a, "R9", "request held", be_valid, 1);
          chk(wait_n == 1'b0, "R7", "wait held", wait_n, 0);
        end
        be_ready = 1'b1;
        be_rdata = mem_val(a);
        @(negedge clk);
        be_ready = 1'b0;
        be_rdata = 8'hEE;
        chk(wait_n == 1'b1, "R7", "wait released after ack", wait_n, 1);
        chk(be_valid == 1'b0, "R9", "request retired", be_valid, 0);
        chk(d_oe == rd, "R8", "drive only on read", d_oe, rd);
        if (rd) chk(d_out == mem_val(a), "R8", "read data", d_out, mem_val(a));
      end
    end
    set_stb(6'h3F);
    repeat (S + 2) @(negedge clk);
    chk(d_oe == 1'b0 && wait_n == 1'b1, "R1", "idle after withdraw", {d_oe, wait_n}, 1);
  endtask

  initial begin
    int unused_seed;
    logic [5:0] pats [6] = '{6'h27, 6'h2B, 6'h07, 6'h0B, 6'h0D, 6'h0E};
    unused_seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(func_rst == 1'b1, "R12", "func reset in reset", func_rst, 1);
    chk(wait_n == 1'b1 && d_oe == 1'b0 && be_valid == 1'b0, "R1", "reset outputs",
        {wait_n, d_oe, be_valid}, 3'b100);
    rst = 1'b0;
    @(negedge clk);
    chk(func_rst == 1'b0, "R12", "func reset released", func_rst, 0);
    chk(stschg_n == 1'b1, "R12", "stschg idle", stschg_n, 1);

    access(6'h37, 10'h012, 8'h00, 0, "R1");   // ce1 high, oe low
    access(6'h3D, 10'h013, 8'h00, 0, "R1");
    access(6'h0D, 10'h020, 8'h00, 0, "R11");  // io read, unconfigured
    access(6'h0E, 10'h021, 8'h55, 0, "R11");
    access(6'h07, CFG, 8'h00, 0, "R11");      // cfg read = 0 after reset
    access(6'h0B, CFG, 8'hC0, 0, "R11");      // index zero
    access(6'h0D, 10'h020, 8'h00, 0, "R11");
    access(6'h0B, CFG, 8'h41, 0, "R11");
    access(6'h07, CFG, 8'h00, 0, "R10");
    access(6'h0D, 10'h031, 8'h00, 2, "R4");
    access(6'h0E, 10'h030, 8'h9A, 0, "R4");
    access(6'h27, 10'h100, 8'h00, 0, "R2");
    access(6'h27, 10'h101, 8'h00, 3, "R6");
    access(6'h2B, 10'h2A7, 8'h6B, 1, "R2");
    access(6'h07, 10'h3F9, 8'h00, 1, "R3");   // odd neighbour of cfg
    access(6'h0B, 10'h3FA, 8'h77, 0, "R3");
    access(6'h23, 10'h044, 8'h00, 0, "R5");   // oe and we both low
    access(6'h25, 10'h045, 8'h00, 0, "R5");   // reg high with iord low
    access(6'h05, 10'h046, 8'h00, 0, "R5");   // attr read plus iord
    access(6'h0C, 10'h047, 8'h00, 0, "R5");   // both io strobes

    @(negedge clk); wake = 1'b1;
    @(negedge clk);
    chk(stschg_n == 1'b0, "R12", "wake shown", stschg_n, 0);
    wake = 1'b0;
    @(negedge clk);
    chk(stschg_n == 1'b1, "R12", "wake cleared", stschg_n, 1);

    for (int n = 0; n < 80; n++) begin
      logic [5:0] s;
      logic [AW-1:0] a;
      if ($urandom % 2) s = pats[$urandom % 6];
      else begin
        s = 6'($urandom);
        if ($urandom % 8 != 0) s[4] = 1'b0;
      end
      a = AW'($urandom);
      if (a == CFG) a = a ^ 10'h002;
      access(s, a, 8'($urandom), $urandom % 5, "R5");
    end

    @(negedge clk); rst = 1'b1;
    cor_model = '0;
    @(negedge clk);
    chk(func_rst == 1'b1, "R12", "func reset again", func_rst, 1);
    rst = 1'b0;
    access(6'h0D, 10'h020, 8'h00, 0, "R11");
    access(6'h07, CFG, 8'h00, 0, "R11");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule